// File: doc/BRIEF.md
# Serial Transmitter with Modem Auto-Enable

This block serializes bytes from a host onto a single TXD line. A host writes one byte into a one-entry holding buffer. The engine moves that byte into a shift register and clocks it out one bit per bit-clock enable pulse. The engine has two framings. In asynchronous framing each character gets a start bit and a stop bit. In synchronous framing raw 8-bit characters are sent back to back. When no character is queued in synchronous framing, the engine sends an idle pattern, which is either all ones or a repeating 0x7E byte.

A single auto-enable input decides the role of the CTS input and the RTS output:

- **Auto-enable low:** CTS and RTS are plain pins. CTS is only reported back on a status output, and RTS simply mirrors a control bit.
- **Auto-enable high:** CTS gates transmission at character boundaries. In asynchronous framing, RTS is also pulled low while a character is in flight. In synchronous framing, a CTS stop raises the underrun flag.

Top module: `sxm_modem_tx`

## Requirements
- R1: With the framing select low (asynchronous), a character is sent as one low start bit, eight data bits LSB first and one high stop bit. TXD advances exactly one bit per clock cycle in which the bit-clock enable is high.
- R2: With the framing select high (synchronous), a character is sent as eight data bits LSB first with no framing bits. A character that is waiting in the buffer starts on the bit slot right after the previous character's last bit.
- R3: The buffer holds one byte. It reads full from the cycle after an accepted write until the cycle after the byte moves to the shift register. A write while full is dropped, and the dropped byte is never sent.
- R4: With auto-enable low, CTS has no effect on transmission, and RTS equals the control RTS bit in every cycle.
- R5: With auto-enable high in asynchronous framing, CTS high never cuts a character short. At each character boundary where CTS is high, the engine holds TXD high, and a full buffer stays full.
- R6: With auto-enable high in synchronous framing, CTS high lets the current character finish. The buffer is then not unloaded, and the underrun flag is set.
- R7: In synchronous framing with no character loaded, TXD sends ones when the idle select is 0. When the idle select is 1, TXD sends 0x7E repeatedly LSB first (0,1,1,1,1,1,1,0), starting from bit 0 at the first idle slot.
- R8: The underrun flag is set when a synchronous character ends and no next character is loaded, whether the buffer was empty or CTS blocked the load. A one-cycle clear strobe clears it, and a set in the same cycle wins.
- R9: With auto-enable high in asynchronous framing, RTS is low from the load of a character through its stop bit. RTS returns to the control RTS bit at the bit-clock enable after the stop bit, if no new character is loaded there.
- R10: In synchronous framing, RTS equals the control RTS bit regardless of transmit activity.
- R11: After CTS returns low, the engine loads a full buffer at the next bit-clock enable, and TXD shows the first bit of the new character from that edge.
- R12: With transmit enable low, TXD is high in the following cycle, any character in flight is abandoned, and RTS equals the control RTS bit. The buffer keeps its contents.
- R13: The CTS status output equals the CTS input one clock later, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_en_i | input | 1 | Transmitter enable |
| sync_mode_i | input | 1 | Framing select: 0 asynchronous, 1 synchronous |
| auto_en_i | input | 1 | Modem auto-enable |
| bit_en_i | input | 1 | Bit-clock enable, one bit per high cycle |
| wr_i | input | 1 | Buffer write strobe |
| wdata_i | input | 8 | Buffer write data |
| buf_full_o | output | 1 | Buffer holds an unsent byte |
| cts_i | input | 1 | Clear-to-send input, high blocks when auto-enabled |
| cts_sts_o | output | 1 | Registered CTS for host reading |
| rts_bit_i | input | 1 | Control-register RTS bit |
| rts_o | output | 1 | Request-to-send output |
| idle_sel_i | input | 1 | Synchronous idle select: 0 ones, 1 repeating 0x7E |
| udr_clr_i | input | 1 | Underrun flag clear strobe |
| udr_flag_o | output | 1 | Underrun status flag |
| txd_o | output | 1 | Serial transmit data |

## Verification
On every cycle, the assertions check the following properties:

- TXD only moves on a bit-clock enable or on disable.
- A full buffer only empties through a load, and CTS blocks that load.
- RTS mirrors the control bit whenever auto-enable is low or the framing is synchronous.
- RTS is low while an auto-enabled asynchronous character is in flight.
- The clear strobe clears the underrun flag.

Some behaviour can only be shown by bench scenarios, which follow the bit stream itself. These include:

- the start, data and stop bit order;
- back-to-back synchronous characters;
- the 0x7E idle sequence and where it starts;
- the one-slot delay of RTS after the stop bit;
- a character that finishes after CTS rises mid-character;
- resume timing when CTS falls.

// File: rtl/sxm_pkg.sv
package sxm_pkg;
  parameter int unsigned SXM_DATA_W = 8;

  typedef enum logic {
    MODE_ASYNC = 1'b0,
    MODE_SYNC  = 1'b1
  } tx_mode_e;
endpackage

// File: rtl/sxm_txbuf.sv
module sxm_txbuf #(
  parameter int unsigned DATA_W = sxm_pkg::SXM_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (pop_i) begin
      full_q <= 1'b0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wdata_i;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;
endmodule

// File: rtl/sxm_txshift.sv
module sxm_txshift
  import sxm_pkg::*;
#(
  parameter int unsigned       DATA_W   = SXM_DATA_W,
  parameter logic [DATA_W-1:0] IDLE_PAT = 8'h7E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              bit_en_i,
  input  tx_mode_e          mode_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ldata_i,
  input  logic              idle_sel_i,
  output logic              txd_o,
  output logic              busy_o,
  output logic              bnd_o
);
  localparam int unsigned SH_W  = DATA_W + 1;
  localparam int unsigned CNT_W = $clog2(DATA_W + 2);
  localparam int unsigned PH_W  = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] ASYNC_REM = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] SYNC_REM  = CNT_W'(DATA_W - 1);
  localparam logic [PH_W-1:0]  PH_LAST   = PH_W'(DATA_W - 1);

  logic             txd_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic [PH_W-1:0]  ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txd_q  <= 1'b1;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else if (!tx_en_i) begin
      txd_q  <= 1'b1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      ph_q   <= '0;
    end else if (bit_en_i) begin
      if (cnt_q != '0) begin
        txd_q <= sh_q[0];
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q - 1'b1;
      end else if (load_i) begin
        busy_q <= 1'b1;
        ph_q   <= '0;
        if (mode_i == MODE_SYNC) begin
          txd_q <= ldata_i[0];
          sh_q  <= {2'b00, ldata_i[DATA_W-1:1]};
          cnt_q <= SYNC_REM;
        end else begin
          txd_q <= 1'b0;                  // start bit
          sh_q  <= {1'b1, ldata_i};       // stop bit above data
          cnt_q <= ASYNC_REM;
        end
      end else begin
        busy_q <= 1'b0;
        if (mode_i == MODE_SYNC && idle_sel_i) begin
          txd_q <= IDLE_PAT[ph_q];
          ph_q  <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        end else begin
          txd_q <= 1'b1;
        end
      end
    end
  end

  assign txd_o  = txd_q;
  assign busy_o = busy_q;
  assign bnd_o  = (cnt_q == '0);
endmodule

// File: rtl/sxm_modem.sv
module sxm_modem (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_en_i,
  input  logic auto_en_i,
  input  logic sync_i,
  input  logic cts_i,
  input  logic bit_en_i,
  input  logic bnd_i,
  input  logic busy_i,
  input  logic buf_full_i,
  input  logic rts_bit_i,
  input  logic udr_clr_i,
  output logic load_o,
  output logic rts_o,
  output logic udr_flag_o,
  output logic cts_sts_o
);
  logic cts_block;
  logic slot;
  logic udr_set;
  logic udr_q;
  logic cts_q;

  assign cts_block = auto_en_i & cts_i;
  assign slot      = tx_en_i & bit_en_i & bnd_i;
  assign load_o    = slot & buf_full_i & ~cts_block;
  // synchronous character ended with nothing following
  assign udr_set   = slot & sync_i & busy_i & ~load_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      udr_q <= 1'b0;
      cts_q <= 1'b0;
    end else begin
      cts_q <= cts_i;
      if (udr_set)        udr_q <= 1'b1;
      else if (udr_clr_i) udr_q <= 1'b0;
    end
  end

  assign rts_o      = (auto_en_i & ~sync_i & tx_en_i & busy_i) ? 1'b0 : rts_bit_i;
  assign udr_flag_o = udr_q;
  assign cts_sts_o  = cts_q;
endmodule

// File: rtl/sxm_modem_tx.sv
module sxm_modem_tx
  import sxm_pkg::*;
#(
  parameter int unsigned       DATA_W   = SXM_DATA_W,
  parameter logic [DATA_W-1:0] IDLE_PAT = 8'h7E
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              sync_mode_i,
  input  logic              auto_en_i,
  input  logic              bit_en_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              buf_full_o,
  input  logic              cts_i,
  output logic              cts_sts_o,
  input  logic              rts_bit_i,
  output logic              rts_o,
  input  logic              idle_sel_i,
  input  logic              udr_clr_i,
  output logic              udr_flag_o,
  output logic              txd_o
);
  logic              load;
  logic              busy;
  logic              bnd;
  logic              full;
  logic [DATA_W-1:0] bdata;
  tx_mode_e          mode;

  assign mode = tx_mode_e'(sync_mode_i);

  sxm_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .wdata_i (wdata_i),
    .pop_i   (load),
    .full_o  (full),
    .data_o  (bdata)
  );

  sxm_txshift #(.DATA_W(DATA_W), .IDLE_PAT(IDLE_PAT)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .bit_en_i   (bit_en_i),
    .mode_i     (mode),
    .load_i     (load),
    .ldata_i    (bdata),
    .idle_sel_i (idle_sel_i),
    .txd_o      (txd_o),
    .busy_o     (busy),
    .bnd_o      (bnd)
  );

  sxm_modem u_modem (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_en_i    (tx_en_i),
    .auto_en_i  (auto_en_i),
    .sync_i     (sync_mode_i),
    .cts_i      (cts_i),
    .bit_en_i   (bit_en_i),
    .bnd_i      (bnd),
    .busy_i     (busy),
    .buf_full_i (full),
    .rts_bit_i  (rts_bit_i),
    .udr_clr_i  (udr_clr_i),
    .load_o     (load),
    .rts_o      (rts_o),
    .udr_flag_o (udr_flag_o),
    .cts_sts_o  (cts_sts_o)
  );

  assign buf_full_o = full;
endmodule

// File: rtl/sxm_modem_tx_chk.sv
module sxm_modem_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic sync_mode_i,
  input logic auto_en_i,
  input logic bit_en_i,
  input logic cts_i,
  input logic rts_bit_i,
  input logic udr_clr_i,
  input logic txd_o,
  input logic rts_o,
  input logic buf_full_o,
  input logic udr_flag_o,
  input logic busy_i,
  input logic load_i
);
  AST_TXD_BIT_PACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(txd_o) |-> ($past(bit_en_i) || !$past(tx_en_i))); // R1
  AST_FULL_NO_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_full_o && !load_i |=> buf_full_o); // R3
  AST_LOAD_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !buf_full_o); // R3
  AST_GP_RTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_en_i |-> rts_o == rts_bit_i); // R4
  AST_CTS_HOLDS_BUF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i && cts_i && buf_full_o |=> buf_full_o); // R5
  AST_UDR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    udr_clr_i && !bit_en_i |=> !udr_flag_o); // R8
  AST_ASYNC_RTS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_en_i && !sync_mode_i && tx_en_i && busy_i |-> !rts_o); // R9
  AST_SYNC_RTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_mode_i |-> rts_o == rts_bit_i); // R10
  AST_DIS_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |=> txd_o); // R12
endmodule

bind sxm_modem_tx sxm_modem_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tx_en_i     (tx_en_i),
  .sync_mode_i (sync_mode_i),
  .auto_en_i   (auto_en_i),
  .bit_en_i    (bit_en_i),
  .cts_i       (cts_i),
  .rts_bit_i   (rts_bit_i),
  .udr_clr_i   (udr_clr_i),
  .txd_o       (txd_o),
  .rts_o       (rts_o),
  .buf_full_o  (buf_full_o),
  .udr_flag_o  (udr_flag_o),
  .busy_i      (busy),
  .load_i      (load)
);

// File: tb/sxm_modem_tx_tb_top.sv
module sxm_modem_tx_tb_top;
  localparam logic [7:0] IDLE = 8'h7E;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       tx_en = 1'b0, sync_m = 1'b0, auto_en = 1'b0, bit_en = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic       cts = 1'b0, rts_bit = 1'b0, idle_sel = 1'b0, udr_clr = 1'b0;
  logic       buf_full, cts_sts, rts, udr_flag, txd;

  sxm_modem_tx dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .sync_mode_i(sync_m),
    .auto_en_i(auto_en), .bit_en_i(bit_en), .wr_i(wr), .wdata_i(wdata),
    .buf_full_o(buf_full), .cts_i(cts), .cts_sts_o(cts_sts), .rts_bit_i(rts_bit),
    .rts_o(rts), .idle_sel_i(idle_sel), .udr_clr_i(udr_clr),
    .udr_flag_o(udr_flag), .txd_o(txd)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  // reference state
  bit       m_q[$];
  bit       m_txd = 1'b1, m_busy = 1'b0, m_full = 1'b0, m_udr = 1'b0, m_cts = 1'b0;
  bit [7:0] m_data = '0;
  int       m_ph = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    bit ld = 1'b0;
    bit uset = 1'b0;
    if (!tx_en) begin
      m_q.delete(); m_txd = 1'b1; m_busy = 1'b0; m_ph = 0;
    end else if (bit_en) begin
      if (m_q.size() != 0) m_txd = m_q.pop_front();
      else if (m_full && !(auto_en && cts)) begin
        ld = 1'b1; m_busy = 1'b1; m_ph = 0;
        if (!sync_m) m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(m_data[i]);
        if (!sync_m) m_q.push_back(1'b1);
        m_txd = m_q.pop_front();
      end else begin
        if (sync_m && m_busy) uset = 1'b1;
        m_busy = 1'b0;
        if (sync_m && idle_sel) begin
          m_txd = IDLE[m_ph]; m_ph = (m_ph + 1) % 8;
        end else m_txd = 1'b1;
      end
    end
    if (ld) m_full = 1'b0;
    else if (wr && !m_full) begin m_full = 1'b1; m_data = wdata; end
    if (uset) m_udr = 1'b1;
    else if (udr_clr) m_udr = 1'b0;
    m_cts = cts;
  endtask

  task automatic compare_all();
    bit exp_rts = (auto_en && !sync_m && tx_en && m_busy) ? 1'b0 : rts_bit;
    chk(sync_m ? "R2" : "R1", "txd", txd, m_txd);
    chk("R3", "buf_full", buf_full, m_full);
    chk(!auto_en ? "R4" : (sync_m ? "R10" : "R9"), "rts", rts, exp_rts);
    chk("R8", "udr_flag", udr_flag, m_udr);
    chk("R13", "cts_sts", cts_sts, m_cts);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic bitstep();
    bit_en = 1'b1; step(); bit_en = 1'b0; step(); step();
  endtask

  task automatic write_byte(input logic [7:0] d);
    wr = 1'b1; wdata = d; step(); wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "reset txd", txd, 1);
    chk("R3", "reset buf_full", buf_full, 0);
    chk("R8", "reset udr", udr_flag, 0);

    // R1/R3: async frame, second write while full dropped
    tx_en = 1'b1; rts_bit = 1'b1;
    write_byte(8'hA5);
    chk("R3", "full after write", buf_full, 1);
    write_byte(8'h3C);
    bitstep();
    chk("R1", "start bit", txd, 0);
    chk("R3", "empty after load", buf_full, 0);
    for (int i = 0; i < 8; i++) begin
      bitstep();
      chk("R1", "data bit", txd, (8'hA5 >> i) & 1);
    end
    bitstep();
    chk("R1", "stop bit", txd, 1);
    for (int i = 0; i < 12; i++) bitstep();
    chk("R3", "dropped byte not sent", txd, 1);

    // R4: auto off, CTS high ignored
    cts = 1'b1; rts_bit = 1'b0;
    write_byte(8'h01);
    bitstep();
    chk("R4", "cts ignored start", txd, 0);
    chk("R4", "rts mirrors bit", rts, 0);
    for (int i = 0; i < 10; i++) bitstep();

    // R5/R11/R9: async auto, CTS blocks then releases
    auto_en = 1'b1; rts_bit = 1'b1;
    write_byte(8'h0F);
    for (int i = 0; i < 12; i++) bitstep();
    chk("R5", "held mark", txd, 1);
    chk("R5", "buffer kept", buf_full, 1);
    chk("R9", "rts idle high", rts, 1);
    cts = 1'b0;
    bitstep();
    chk("R11", "resume start bit", txd, 0);
    chk("R9", "rts low in char", rts, 0);
    write_byte(8'hF0);
    cts = 1'b1;
    for (int i = 0; i < 9; i++) bitstep();
    chk("R5", "char finished stop", txd, 1);
    chk("R9", "rts low at stop", rts, 0);
    bitstep();
    chk("R9", "rts high after stop", rts, 1);
    chk("R5", "no transfer under cts", buf_full, 1);
    cts = 1'b0;
    for (int i = 0; i < 11; i++) bitstep();

    // R6/R7/R8/R10: sync auto, CTS underrun, 0x7E idle
    sync_m = 1'b1; idle_sel = 1'b1; rts_bit = 1'b0;
    write_byte(8'h81);
    bitstep();
    chk("R2", "sync bit0", txd, 1);
    chk("R10", "rts follows bit", rts, 0);
    write_byte(8'h22);
    bitstep(); bitstep();
    cts = 1'b1;
    for (int i = 0; i < 5; i++) bitstep();
    chk("R2", "sync bit7", txd, 1);
    bitstep();
    chk("R6", "underrun set", udr_flag, 1);
    chk("R6", "buffer kept", buf_full, 1);
    chk("R7", "idle bit0", txd, 0);
    for (int i = 1; i < 16; i++) begin
      bitstep();
      chk("R7", "idle pattern", txd, (IDLE >> (i % 8)) & 1);
    end
    udr_clr = 1'b1; step(); udr_clr = 1'b0;
    chk("R8", "underrun cleared", udr_flag, 0);
    cts = 1'b0; idle_sel = 1'b0;
    bitstep();
    chk("R11", "sync resume bit0", txd, 0);
    for (int i = 0; i < 8; i++) bitstep();
    chk("R7", "idle ones", txd, 1);
    chk("R8", "empty-buffer underrun", udr_flag, 1);

    // R12: disable mid character
    sync_m = 1'b0; auto_en = 1'b1; rts_bit = 1'b1;
    write_byte(8'h00);
    bitstep(); bitstep(); bitstep();
    chk("R9", "rts low", rts, 0);
    tx_en = 1'b0; step();
    chk("R12", "mark when disabled", txd, 1);
    chk("R12", "rts bit when disabled", rts, 1);
    tx_en = 1'b1;
    cts = 1'b1; step(); cts = 1'b0;
    chk("R13", "cts status", cts_sts, 1);

    // random mix
    for (int seg = 0; seg < 24; seg++) begin
      sync_m = $urandom % 2; auto_en = $urandom % 2;
      idle_sel = $urandom % 2; rts_bit = $urandom % 2;
      if (seg % 4 == 0) begin tx_en = 1'b0; step(); step(); tx_en = 1'b1; end
      for (int c = 0; c < 500; c++) begin
        bit_en  = ($urandom % 3) == 0;
        wr      = ($urandom % 4) == 0;
        wdata   = 8'($urandom);
        udr_clr = ($urandom % 30) == 0;
        if (($urandom % 40) == 0) cts = ~cts;
        if (($urandom % 50) == 0) rts_bit = ~rts_bit;
        step();
      end
      bit_en = 1'b0; wr = 1'b0; udr_clr = 1'b0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule